// File: doc/BRIEF.md
# Idempotent Check-Event Filter

This block sits in front of a software monitor that checks every memory access of a running program. Many such checks are redundant: if the same kind of access to the same word was checked before, and nothing that could change the answer has happened since, the check gives the same result again. The filter keeps a small table of recently forwarded (access kind, word address) keys. An event whose key is in the table is consumed and dropped. An event whose key is absent is forwarded downstream and its key is recorded.

The monitored program's semantic events, such as a deallocation or a lock/unlock, reach the block as invalidations. A global invalidate empties the table. An address invalidate removes the entries for one word, both kinds. Loads and stores are keyed apart, so the first store to a word is still forwarded after a load to it has been filtered. Events flagged as non-filterable always pass and are never recorded. The check itself happens downstream.

Both event sides use valid/ready handshakes. Lookup is combinational, so a forwarded event appears on the output in the same cycle it is presented.

Top module: `idem_filter`

## Requirements
- R1: After reset the table is empty: out_valid is 0 while in_valid is 0, and the first event of any key is forwarded.
- R2: A missing filterable event is forwarded in the same cycle with kind, address and payload unchanged; out_valid equals in_valid and in_ready equals out_ready.
- R3: An event whose key (kind and address) is recorded and not invalidated in that cycle is accepted (in_ready 1) with out_valid 0, whatever out_ready is.
- R4: Access kind is part of the key (0 = load, 1 = store): a store to a word whose load is recorded is forwarded, and the reverse.
- R5: An event with in_nofilt set is forwarded even when its key is recorded, takes in_ready from out_ready, and is never recorded.
- R6: A global invalidate removes every entry in one cycle; events in later cycles miss until they are recorded again.
- R7: An address invalidate removes the entries of that word for both kinds and leaves entries of other words intact.
- R8: Keys are recorded in round-robin slots: the Nth insertion since reset or since the last global invalidate goes to slot N mod DEPTH and evicts whatever is there.
- R9: A miss that is not accepted (out_ready 0) is not recorded and keeps in_ready at 0.
- R10: An invalidation presented in the same cycle as an event takes effect first: the event is judged against the table after the invalidation, and if it misses and is accepted, its key is recorded after the invalidation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Event present |
| in_ready | output | 1 | Event consumed this cycle |
| in_kind | input | 1 | Access kind: 0 load, 1 store |
| in_addr | input | ADDR_W | Word address |
| in_nofilt | input | 1 | Event must not be filtered or recorded |
| in_data | input | DATA_W | Payload carried to the output |
| out_valid | output | 1 | Forwarded event present |
| out_ready | input | 1 | Downstream accepts the event |
| out_kind | output | 1 | Forwarded access kind |
| out_addr | output | ADDR_W | Forwarded word address |
| out_nofilt | output | 1 | Forwarded non-filterable flag |
| out_data | output | DATA_W | Forwarded payload |
| inv_all | input | 1 | Clear the whole table |
| inv_addr_valid | input | 1 | Clear entries of inv_addr |
| inv_addr | input | ADDR_W | Word address to clear |

## Verification
A stale entry that survives an invalidation shows up at once as a dropped event: the next access to that word finds out_valid at 0 when the reference expects a forwarded event. A lost entry or a wrong replacement slot shows up as an extra forwarded event, but only when that key is presented again. The bench replays directed sequences and a random stream over a narrow address range so that keys recur often, and it compares the handshake and forwarded fields with a behavioural slot model on every clock. A corrupt table therefore surfaces within a few events.

// File: rtl/idf_pkg.sv
package idf_pkg;
   typedef enum logic {
      ACC_LOAD  = 1'b0,
      ACC_STORE = 1'b1
   } acc_kind_e;

   localparam int unsigned MIN_DEPTH = 8;
   localparam int unsigned MAX_DEPTH = 256;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/idf_match.sv
module idf_match #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DEPTH  = 16
) (
   input  logic [DEPTH-1:0]             ent_valid,
   input  logic [DEPTH-1:0]             ent_kind,
   input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
   input  logic                         q_kind,
   input  logic [ADDR_W-1:0]            q_addr,
   input  logic                         inv_all,
   input  logic                         inv_addr_valid,
   input  logic [ADDR_W-1:0]            inv_addr,
   output logic [DEPTH-1:0]             hit_vec,
   output logic [DEPTH-1:0]             kill_vec
);
   // Per-slot comparators; a slot hit only counts if the slot survives
   // the invalidation presented in the same cycle.
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic key_eq;
      logic inv_eq;
      assign key_eq      = (ent_kind[g] == q_kind) && (ent_addr[g] == q_addr);
      assign inv_eq      = inv_addr_valid && (ent_addr[g] == inv_addr);
      assign kill_vec[g] = inv_all || inv_eq;
      assign hit_vec[g]  = ent_valid[g] && key_eq && !kill_vec[g];
   end
endmodule

// File: rtl/idf_ring_ptr.sv
module idf_ring_ptr #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic             advance,
   output logic [PTR_W-1:0] slot
);
   import idf_pkg::*;

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] base;
   logic [PTR_W-1:0] base_inc;

   assign base = restart ? '0 : ptr_q;
   assign slot = base;

   if (is_pow2(DEPTH)) begin : g_wrap_free
      assign base_inc = base + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign base_inc = (base == PTR_W'(DEPTH - 1)) ? '0 : base + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr_q <= '0;
      end else if (advance) begin
         ptr_q <= base_inc;
      end else if (restart) begin
         ptr_q <= '0;
      end
   end
endmodule

// File: rtl/idf_entries.sv
module idf_entries #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned PTR_W  = $clog2(DEPTH)
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [DEPTH-1:0]             kill_vec,
   input  logic                         wr_en,
   input  logic [PTR_W-1:0]             wr_slot,
   input  logic                         wr_kind,
   input  logic [ADDR_W-1:0]            wr_addr,
   output logic [DEPTH-1:0]             ent_valid,
   output logic [DEPTH-1:0]             ent_kind,
   output logic [DEPTH-1:0][ADDR_W-1:0] ent_addr
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic sel;
      assign sel = wr_en && (wr_slot == PTR_W'(g));

      // Write beats kill: the invalidation is ordered before the insert.
      always_ff @(posedge clk) begin
         if (rst) begin
            ent_valid[g] <= 1'b0;
         end else if (sel) begin
            ent_valid[g] <= 1'b1;
         end else if (kill_vec[g]) begin
            ent_valid[g] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            ent_kind[g] <= wr_kind;
            ent_addr[g] <= wr_addr;
         end
      end
   end
endmodule

// File: rtl/idem_filter.sv
module idem_filter #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_kind,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_nofilt,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_kind,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_nofilt,
   output logic [DATA_W-1:0] out_data,
   input  logic              inv_all,
   input  logic              inv_addr_valid,
   input  logic [ADDR_W-1:0] inv_addr
);
   import idf_pkg::*;

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < MIN_DEPTH || DEPTH > MAX_DEPTH) begin : g_bad_depth
      $error("idem_filter: DEPTH out of supported range");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("idem_filter: ADDR_W and DATA_W must be at least 1");
   end

   logic [DEPTH-1:0]             ent_valid;
   logic [DEPTH-1:0]             ent_kind;
   logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
   logic [DEPTH-1:0]             hit_vec;
   logic [DEPTH-1:0]             kill_vec;
   logic [PTR_W-1:0]             wr_slot;
   logic                         filt_hit;
   logic                         insert;

   idf_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_match (
      .ent_valid      (ent_valid),
      .ent_kind       (ent_kind),
      .ent_addr       (ent_addr),
      .q_kind         (in_kind),
      .q_addr         (in_addr),
      .inv_all        (inv_all),
      .inv_addr_valid (inv_addr_valid),
      .inv_addr       (inv_addr),
      .hit_vec        (hit_vec),
      .kill_vec       (kill_vec)
   );

   assign filt_hit  = (|hit_vec) && !in_nofilt;
   assign out_valid = in_valid && !filt_hit;
   assign in_ready  = filt_hit || out_ready;
   assign out_kind  = in_kind;
   assign out_addr  = in_addr;
   assign out_nofilt = in_nofilt;
   assign out_data  = in_data;
   assign insert    = in_valid && out_ready && !filt_hit && !in_nofilt;

   idf_ring_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
      .clk     (clk),
      .rst     (rst),
      .restart (inv_all),
      .advance (insert),
      .slot    (wr_slot)
   );

   idf_entries #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_entries (
      .clk       (clk),
      .rst       (rst),
      .kill_vec  (kill_vec),
      .wr_en     (insert),
      .wr_slot   (wr_slot),
      .wr_kind   (in_kind),
      .wr_addr   (in_addr),
      .ent_valid (ent_valid),
      .ent_kind  (ent_kind),
      .ent_addr  (ent_addr)
   );
endmodule

// File: rtl/idf_checker.sv
module idf_checker #(
   parameter int unsigned DEPTH = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             in_ready,
   input logic             in_nofilt,
   input logic             out_valid,
   input logic             out_ready,
   input logic             inv_all,
   input logic [DEPTH-1:0] ent_valid
);
   a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (ent_valid == '0));

   a_r2_output_needs_input: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> in_valid);

   a_r3_drop_is_consumed: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !out_valid) |-> in_ready);

   a_r5_bypass_forwards: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_nofilt) |-> out_valid);

   a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
      inv_all |=> ($countones(ent_valid) <= 1));

   a_r9_stall_holds_input: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);

   a_r9_no_accept_no_growth: assert property (@(posedge clk) disable iff (rst)
      (!(in_valid && out_ready && !in_nofilt) && !inv_all)
      |=> ($countones(ent_valid) <= $countones($past(ent_valid))));
endmodule

bind idem_filter idf_checker #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_nofilt (in_nofilt),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .inv_all   (inv_all),
   .ent_valid (ent_valid)
);

// File: tb/idem_filter_bench.sv
module idem_filter_bench;
   localparam int AW = 16;
   localparam int DW = 8;
   localparam int D  = 8;

   logic          clk = 1'b0;
   logic          rst;
   logic          in_valid, in_kind, in_nofilt, out_ready;
   logic [AW-1:0] in_addr, inv_addr;
   logic [DW-1:0] in_data;
   logic          inv_all, inv_addr_valid;
   logic          in_ready, out_valid, out_kind, out_nofilt;
   logic [AW-1:0] out_addr;
   logic [DW-1:0] out_data;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // reference table: slot-indexed records plus insertion counter
   bit      m_v [D];
   bit      m_k [D];
   int      m_a [D];
   int      m_ptr;

   always #4 clk = ~clk;

   idem_filter #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(D)) u_idem_filter (
      .clk(clk), .rst(rst),
      .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
      .in_addr(in_addr), .in_nofilt(in_nofilt), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
      .out_addr(out_addr), .out_nofilt(out_nofilt), .out_data(out_data),
      .inv_all(inv_all), .inv_addr_valid(inv_addr_valid), .inv_addr(inv_addr)
   );

   function automatic void check(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endfunction

   function automatic bit model_hit(bit k, int a);
      for (int i = 0; i < D; i++) begin
         bit killed = inv_all || (inv_addr_valid && m_a[i] == int'(inv_addr));
         if (m_v[i] && !killed && m_k[i] == k && m_a[i] == a) return 1;
      end
      return 0;
   endfunction

   task automatic step(bit v, bit k, int a, bit nf, bit ordy, bit ia, bit iav,
                       int iad, string tag);
      bit hit, ev, er, ins;
      @(negedge clk);
      in_valid = v; in_kind = k; in_addr = AW'(a); in_nofilt = nf;
      in_data = DW'($urandom); out_ready = ordy;
      inv_all = ia; inv_addr_valid = iav; inv_addr = AW'(iad);
      #1;
      hit = model_hit(k, a) && !nf;
      ev  = v && !hit;
      er  = hit || ordy;
      check(out_valid == ev, tag, "out_valid", out_valid, ev);
      check(in_ready == er, tag, "in_ready", in_ready, er);
      if (ev) begin
         check(out_kind == k && out_addr == AW'(a) && out_data == in_data
               && out_nofilt == nf, tag, "out fields", int'(out_addr), a);
      end
      ins = v && ordy && !hit && !nf;
      @(posedge clk);
      if (ia) begin
         for (int i = 0; i < D; i++) m_v[i] = 0;
         m_ptr = 0;
      end else if (iav) begin
         for (int i = 0; i < D; i++) if (m_a[i] == iad) m_v[i] = 0;
      end
      if (ins) begin
         m_v[m_ptr] = 1; m_k[m_ptr] = k; m_a[m_ptr] = a;
         m_ptr = (m_ptr + 1) % D;
      end
   endtask

   task automatic ev(bit k, int a, string tag);
      step(1, k, a, 0, 1, 0, 0, 0, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < D; i++) begin m_v[i] = 0; m_k[i] = 0; m_a[i] = 0; end
      m_ptr = 0;
      rst = 1; in_valid = 0; in_kind = 0; in_addr = '0; in_nofilt = 0;
      in_data = '0; out_ready = 1; inv_all = 0; inv_addr_valid = 0; inv_addr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 0;

      // R1: idle after reset, first event forwarded
      step(0, 0, 5, 0, 1, 0, 0, 0, "R1");
      ev(0, 5, "R1");
      // R3: repeat is dropped, even with downstream stalled
      ev(0, 5, "R3");
      step(1, 0, 5, 0, 0, 0, 0, 0, "R3");
      // R4: store keyed apart from load
      ev(1, 5, "R4");
      ev(1, 5, "R4");
      // R5: non-filterable passes and is not recorded
      step(1, 0, 5, 1, 1, 0, 0, 0, "R5");
      step(1, 0, 6, 1, 1, 0, 0, 0, "R5");
      ev(0, 6, "R5");
      ev(0, 6, "R5");
      // R9: stalled miss not recorded
      step(1, 0, 7, 0, 0, 0, 0, 0, "R9");
      ev(0, 7, "R9");
      ev(0, 7, "R2");
      // R7: address invalidate hits both kinds of one word only
      step(0, 0, 0, 0, 1, 0, 1, 5, "R7");
      ev(0, 5, "R7");
      ev(1, 5, "R7");
      ev(0, 6, "R7");
      // R10 / R6: global clear in same cycle as event
      step(1, 0, 6, 0, 1, 1, 0, 0, "R10");
      ev(0, 6, "R10");
      ev(0, 7, "R6");
      // R10: address invalidate in same cycle as matching event
      step(1, 0, 7, 0, 1, 0, 1, 7, "R10");
      ev(0, 7, "R10");
      // R8: round-robin eviction
      step(0, 0, 0, 0, 1, 1, 0, 0, "R6");
      for (int i = 0; i < D; i++) ev(1, 100 + i, "R8");
      for (int i = 0; i < D; i++) ev(1, 100 + i, "R8");
      ev(1, 100 + D, "R8");
      ev(1, 100, "R8");
      ev(1, 102, "R8");
      ev(1, 101, "R8");

      // mixed random traffic over a narrow address range
      for (int n = 0; n < 2000; n++) begin
         int r = $urandom_range(0, 99);
         step(($urandom_range(0, 9) < 8), 1'($urandom), $urandom_range(0, 11),
              ($urandom_range(0, 9) == 0), ($urandom_range(0, 3) != 0),
              (r < 2), (r >= 2 && r < 9), $urandom_range(0, 11), "R2");
      end

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule